// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

A synchronous sequencer that turns single-word host requests into correctly timed cycles on an external asynchronous static RAM of 256K words by 16 bits. The host presents an 18-bit word address, write data, a two-bit byte enable and a read/write flag. A request is taken in the cycle the controller is ready. Each request is answered by a one-cycle acknowledge, and a read returns its data with that acknowledge.

On the memory side the controller drives active-low select, output-enable and write-enable strobes, plus one low-active strobe for each byte lane. The data bus is split into a driven half with an enable and a sampled half. The clock period and the memory timing figures are parameters in nanoseconds. Every phase length is the figure rounded up to whole clocks, so the same RTL serves any clock and speed grade.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, select, output enable, write enable and both lane strobes are high, the data drivers are off, the acknowledge is low and the ready output is high.
- R2: Whenever the ready output is high, the memory select is high.
- R3: Byte-enable bit 0 maps to the lower strobe (data bits 7:0) and bit 1 to the upper strobe (bits 15:8). A strobe is low during an access only when its enable bit is 1, and both strobes are high while the select is high.
- R4: A read holds select low, output enable low and write enable high for RD_CYC = ceil(max(access, output-enable, lane access)/clock) cycles. The bus is captured at the end of that phase and the acknowledge rises RD_CYC cycles after acceptance. A lane whose enable bit is 0 returns zero.
- R5: A write holds output enable high and write enable low for WP_CYC = max(ceil(pulse), ceil(data setup), ceil(cycle) − AH_CYC) cycles. It then holds write enable high with select low for AH_CYC = ceil(address hold) cycles. The acknowledge rises WP_CYC + AH_CYC cycles after acceptance. Only enabled lanes are written.
- R6: The data drivers are enabled only during the write pulse and hold phases, and never while output enable is low. While write enable is low they carry the request's write data.
- R7: Address and driven data stay constant for as long as select stays low.
- R8: The acknowledge is high for exactly one cycle per request.
- R9: After a read, select stays high and the drivers stay off for TA_CYC = ceil(bus release/clock) cycles before ready rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (bit 0 lower, bit 1 upper) |
| req_ready | output | 1 | Controller idle; request taken this cycle if valid |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, valid with ack on reads |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 16 | Data sampled from memory |

## Verification
On every cycle the assertions check the following:
- select is high while idle;
- output enable and write enable are never low together, and the drivers never fight a memory read;
- the strobes rest high while the memory is deselected;
- address and data hold still during an access;
- the acknowledge is a single pulse;
- the bus-release window after a read is kept.

Only the bench scenarios can show the rest:
- the exact phase lengths from the rounded timing figures;
- which lane is written or returned for each byte-enable pattern;
- that a disabled lane reads as zero;
- that partial writes leave the other byte of a word intact when it is read back from a memory model.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int CLK_NS   = 8,
  parameter int T_WC_NS  = 17,
  parameter int T_WP_NS  = 14,
  parameter int T_DW_NS  = 10,
  parameter int T_AH_NS  = 2,
  parameter int T_AA_NS  = 17,
  parameter int T_OE_NS  = 10,
  parameter int T_BA_NS  = 10,
  parameter int T_HZ_NS  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          req_ready,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int HB = DW / 2;

  localparam int AH_RAW = (T_AH_NS + CLK_NS - 1) / CLK_NS;
  localparam int AH_CYC = (AH_RAW < 1) ? 1 : AH_RAW;
  localparam int WP_A   = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_B   = (T_DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_C   = (T_WC_NS + CLK_NS - 1) / CLK_NS - AH_CYC;
  localparam int WP_AB  = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int WP_ABC = (WP_AB > WP_C) ? WP_AB : WP_C;
  localparam int WP_CYC = (WP_ABC < 1) ? 1 : WP_ABC;
  localparam int RD_A   = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_B   = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_C   = (T_BA_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_AB  = (RD_A > RD_B) ? RD_A : RD_B;
  localparam int RD_ABC = (RD_AB > RD_C) ? RD_AB : RD_C;
  localparam int RD_CYC = (RD_ABC < 1) ? 1 : RD_ABC;
  localparam int TA_RAW = (T_HZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int TA_CYC = (TA_RAW < 1) ? 1 : TA_RAW;
  localparam int MX1    = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
  localparam int MX2    = (AH_CYC > TA_CYC) ? AH_CYC : TA_CYC;
  localparam int MAXC   = (MX1 > MX2) ? MX1 : MX2;
  localparam int CW     = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TA, S_WR, S_WH} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [1:0]   be_q;

  assign req_ready = (st == S_IDLE);
  assign mem_cs_n  = !(st == S_RD || st == S_WR || st == S_WH);
  assign mem_oe_n  = (st != S_RD);
  assign mem_we_n  = (st != S_WR);
  assign mem_dq_oe = (st == S_WR || st == S_WH);
  assign mem_lb_n  = mem_cs_n | !be_q[0];
  assign mem_ub_n  = mem_cs_n | !be_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      ack        <= 1'b0;
      be_q       <= 2'b00;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr   <= req_addr;
          mem_dq_out <= req_wdata;
          be_q       <= req_be;
          st         <= req_write ? S_WR : S_RD;
          cnt        <= req_write ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
        end
        S_RD: if (cnt == '0) begin
          rd_data <= {be_q[1] ? mem_dq_in[DW-1:HB] : {HB{1'b0}},
                      be_q[0] ? mem_dq_in[HB-1:0]  : {HB{1'b0}}};
          ack     <= 1'b1;
          st      <= S_TA;
          cnt     <= CW'(TA_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_TA: if (cnt == '0) st <= S_IDLE;
              else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          st  <= S_WH;
          cnt <= CW'(AH_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WH: if (cnt == '0) begin
          st  <= S_IDLE;
          ack <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int AW      = 18,
  parameter int DW      = 16,
  parameter int CLK_NS  = 8,
  parameter int T_HZ_NS = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          ack,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  localparam int TA_RAW = (T_HZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int TA     = (TA_RAW < 1) ? 1 : TA_RAW;
  localparam int HW     = $clog2(TA + 1);

  logic [HW-1:0] hz;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hz <= HW'(TA);
    else if (!mem_oe_n) hz <= '0;
    else if (hz < HW'(TA)) hz <= hz + 1'b1;

  AST_IDLE_DESEL: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> mem_cs_n); // R2
  AST_LANES_REST: assert property (@(posedge clk) disable iff (!rst_n) mem_cs_n |-> (mem_lb_n && mem_ub_n)); // R3
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (mem_oe_n && !mem_cs_n)); // R5
  AST_NO_FIGHT:   assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R6
  AST_ADDR_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R7
  AST_ACK_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R8
  AST_RELEASE:    assert property (@(posedge clk) disable iff (!rst_n) (mem_oe_n && hz < HW'(TA)) |-> (mem_cs_n && !mem_dq_oe && !req_ready)); // R9
endmodule

bind sram_lane_ctrl sram_lane_chk #(.AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_HZ_NS(T_HZ_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ack(ack), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
  .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe));

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int CLK = 8;
  localparam int RD_LAT = (17 + CLK - 1) / CLK;
  localparam int WR_LAT = (14 + CLK - 1) / CLK + (2 + CLK - 1) / CLK;
  localparam int TA = (9 + CLK - 1) / CLK;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0] req_be = 0;
  logic req_ready, ack, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rd_data, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;

  always #(CLK/2) clk = ~clk;

  sram_lane_ctrl dut (.*);

  logic [15:0] sram [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] rd_word(input logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  always_comb begin
    logic [15:0] w;
    w = rd_word(sram, int'(mem_addr));
    mem_dq_in = 16'hzzzz;
    if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_in[7:0]  = w[7:0];
      if (!mem_ub_n) mem_dq_in[15:8] = w[15:8];
    end
  end

  always @(posedge clk) if (!mem_cs_n && !mem_we_n) begin
    logic [15:0] w;
    w = rd_word(sram, int'(mem_addr));
    if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
    if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
    sram[int'(mem_addr)] = w;
  end

  typedef struct { bit rd; logic [15:0] data; logic [1:0] be; int due; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    item_t it;
    logic [15:0] w;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    w = rd_word(shadow, int'(a));
    it.rd = !wr; it.be = be; it.due = cyc + 1 + (wr ? WR_LAT : RD_LAT);
    if (wr) begin
      if (be[0]) w[7:0] = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
      it.data = d;
    end else
      it.data = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    q.push_back(it);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  int last_ack = 0;
  bit pend_ta = 0;
  always @(negedge clk) if (rst_n) begin
    if (pend_ta && req_ready) begin
      chk(cyc - last_ack == TA, "R9 turnaround", cyc - last_ack, TA);
      pend_ta = 0;
    end
    if (q.size() > 0 && !mem_cs_n)
      if ({mem_ub_n, mem_lb_n} != ~q[0].be) chk(0, "R3 lane strobes", {mem_ub_n, mem_lb_n}, ~q[0].be);
    if (q.size() > 0 && !mem_we_n)
      if (!(mem_dq_oe && mem_dq_out == q[0].data)) chk(0, "R6 write drive", mem_dq_out, q[0].data);
    if (mem_dq_oe && !mem_oe_n) chk(0, "R6 contention", 1, 0);
    if (req_ready && !mem_cs_n) chk(0, "R2 idle select", mem_cs_n, 1);
    if (ack) begin
      if (q.size() == 0) chk(0, "R8 spurious ack", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(cyc == it.due, it.rd ? "R4 read latency" : "R5 write latency", cyc, it.due);
        if (it.rd) begin
          chk(rd_data == it.data, "R4 read data", rd_data, it.data);
          last_ack = cyc; pend_ta = 1;
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, ack, req_ready} == 8'b11111001,
            "R1 reset state", {mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, ack, req_ready}, 8'b11111001);
        rst_n = 1;
        do_req(1, 18'h00000, 16'hA55A, 2'b11);
        do_req(0, 18'h00000, 16'h0000, 2'b11);
        do_req(1, 18'h3FFFF, 16'h1234, 2'b11);
        do_req(1, 18'h3FFFF, 16'hBEEF, 2'b01);   // R5 lower only
        do_req(0, 18'h3FFFF, 16'h0000, 2'b11);   // expect 12EF
        do_req(1, 18'h3FFFF, 16'hCAFE, 2'b10);   // R5 upper only
        do_req(0, 18'h3FFFF, 16'h0000, 2'b11);   // expect CAEF
        do_req(0, 18'h3FFFF, 16'h0000, 2'b01);   // R4 disabled upper lane reads zero
        do_req(0, 18'h3FFFF, 16'h0000, 2'b10);   // R4 disabled lower lane reads zero
        do_req(1, 18'h00000, 16'hFFFF, 2'b00);   // R3 no lane written
        do_req(0, 18'h00000, 16'h0000, 2'b11);
        for (int i = 0; i < 24; i++)
          do_req(1, 18'(i * 9973), 16'(i * 16'h3B1D + 7), 2'(i % 4));
        for (int i = 0; i < 24; i++)
          do_req(0, 18'(i * 9973), 16'h0000, 2'(3 - i % 4));
        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R8 all acknowledged", q.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule